// File: doc/BRIEF.md
# UART FIFO Status and Interrupt Controller

This block sits between a host register bus and the character path of a UART. It contains a transmit FIFO and a receive FIFO of parameterised depth. Each FIFO has a single-entry hold stage that stands in for a shift register. The transmit stage takes the oldest queued character whenever it is idle, and stays busy until the line side pulses `tx_done`. Characters from the line land in the receive stage and move into the receive FIFO on the next cycle.

The host reaches the block through a byte-wide bus with three locations. Location 0 is the data port: a write queues a character for transmit and a read pops a received character. Location 1 holds the control bits. Location 2 is the status register, which reports both empty conditions and three sticky error events. The events are receive overflow, transmit overflow and receive underflow. Software clears each event by writing a one to its bit. Each event has an enable bit that gates it onto a single registered interrupt line. A receive flush command empties the receive FIFO. The flush never touches the character held in the receive stage, and the transmit-empty indication ignores the transmit stage.

Top module: `uart_fifo_ctrl`

## Requirements
- R1: After reset the status register reads 0xC0, the control register reads 0x00 and `irq` is low.
- R2: Data-port writes queue characters in order. The transmit stage loads the oldest character when it is idle, drives it on `tx_char` with `tx_valid` high, and frees itself on `tx_done`. Status bit 7 (transmit empty) is 1 whenever the transmit FIFO holds nothing, even while the stage is busy.
- R3: A data-port write while the transmit FIFO is full is discarded and sets status bit 1 (transmit overflow).
- R4: Received characters pass through the receive stage into the receive FIFO, and data-port reads return them in arrival order. Status bit 6 (receive empty) is 1 exactly when the receive FIFO holds nothing.
- R5: A character leaving the receive stage while the receive FIFO is full is discarded and sets status bit 2 (receive overflow).
- R6: A data-port read while the receive FIFO is empty returns 0x00 and sets status bit 0 (receive underflow).
- R7: Writing control bit 6 as one empties the receive FIFO. A character held in the receive stage at that moment still enters the FIFO. Writing bit 6 as zero has no effect on the FIFO.
- R8: Writing one to status bit 2, 1 or 0 clears that flag. Writing zero to it leaves the flag unchanged.
- R9: If an event and a clear write hit the same flag in the same cycle, the flag remains set.
- R10: `irq` is driven one cycle after the flags and enables it depends on. It is the OR of (flag AND enable), where control bit 2 enables receive overflow, bit 1 enables transmit overflow and bit 0 enables receive underflow.
- R11: Control bits 7 to 3, status bits 5 to 3 and location 3 always read zero. Control bit 6 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Bus write strobe |
| reg_rd | input | 1 | Bus read strobe |
| reg_addr | input | 2 | Location: 0 data, 1 control, 2 status |
| reg_wdata | input | 8 | Bus write data |
| reg_rdata | output | 8 | Bus read data, valid in the cycle of the read strobe |
| tx_valid | output | 1 | Transmit stage holds a character |
| tx_char | output | 8 | Character in the transmit stage |
| tx_done | input | 1 | Line side has finished with the transmit stage |
| rx_in_valid | input | 1 | A received character is presented |
| rx_in_char | input | 8 | Received character |
| irq | output | 1 | Registered host interrupt |

## Verification
A data write updates the transmit FIFO at the clock edge that takes it. The transmit stage loads on the following edge, so the bench reads status between those two edges to see transmit-empty low, and reads it again after the load to see it high. A received character enters its stage on the first edge and the FIFO on the second, so the overflow flag appears after the second edge and `irq` after a third. The bench waits out each of these counts before it samples. All sampling happens at the falling edge, and bus read data is combinational within the strobe cycle. The same-cycle clear case is timed so that the write strobe coincides with the edge where the stage pushes into a full FIFO.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] LOC_DATA = 2'd0;
  localparam logic [ADDR_W-1:0] LOC_CTRL = 2'd1;
  localparam logic [ADDR_W-1:0] LOC_STAT = 2'd2;

  // event flag order; also the bit position in status and enable fields
  localparam int EV_RXUND = 0;
  localparam int EV_TXOVF = 1;
  localparam int EV_RXOVF = 2;
  localparam int NUM_EV   = 3;

  localparam int CTL_FLUSH_BIT = 6;
  localparam int ST_RXEMP_BIT  = 6;
  localparam int ST_TXEMP_BIT  = 7;
endpackage

// File: rtl/uart_sfifo.sv
module uart_sfifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic               push,
  input  logic [W-1:0]       din,
  input  logic               pop,
  output logic [W-1:0]       dout,
  output logic               empty,
  output logic               full,
  output logic               push_drop
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);
  localparam logic [PW-1:0] PTR_MAX = PW'(DEPTH - 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] rd_q, rd_d, wr_q, wr_d, wr_at;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign empty     = (cnt_q == '0);
  assign full      = (cnt_q == CNT_MAX);
  assign do_push   = push && (!full || flush);
  assign do_pop    = pop && !empty && !flush;
  assign push_drop = push && full && !flush;
  assign dout      = mem_q[rd_q];
  assign wr_at     = flush ? '0 : wr_q;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PTR_MAX) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    rd_d  = rd_q;
    wr_d  = wr_q;
    cnt_d = cnt_q;
    if (flush) begin
      rd_d  = '0;
      wr_d  = do_push ? nxt('0) : '0;
      cnt_d = do_push ? CW'(1) : '0;
    end else begin
      if (do_push) wr_d = nxt(wr_q);
      if (do_pop)  rd_d = nxt(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wr_at] <= din;
  end

  AST_FULL_PUSH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !flush) |=> $stable(cnt_q)); // R3
  AST_EMPTY_POP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push && !flush) |=> (cnt_q == '0)); // R6
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cnt_q <= CW'(1))); // R7
endmodule

// File: rtl/uart_evt_flags.sv
module uart_evt_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] en,
  output logic [N-1:0] flag,
  output logic         irq
);
  logic [N-1:0] flag_d;
  logic         irq_d;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_comb begin
      flag_d[i] = flag[i];
      if (clr[i]) flag_d[i] = 1'b0;
      if (evt[i]) flag_d[i] = 1'b1;
    end

    AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      evt[i] |=> flag[i]); // R9
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && !evt[i]) |=> !flag[i]); // R8
  end

  assign irq_d = |(flag & en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= '0;
      irq  <= 1'b0;
    end else begin
      flag <= flag_d;
      irq  <= irq_d;
    end
  end

  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (|(flag & en)) |=> irq); // R10
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(flag & en)) |=> !irq); // R10
endmodule

// File: rtl/uart_fifo_ctrl.sv
module uart_fifo_ctrl
  import uart_fifo_pkg::*;
#(
  parameter int TX_DEPTH = 4,
  parameter int RX_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              tx_valid,
  output logic [7:0]        tx_char,
  input  logic              tx_done,
  input  logic              rx_in_valid,
  input  logic [7:0]        rx_in_char,
  output logic              irq
);
  logic wr_data, wr_ctrl, wr_stat, rd_data;
  logic rx_flush;
  logic [NUM_EV-1:0] en_q, en_d, evt, clr, flag;

  logic       txf_empty, txf_full, txf_drop, tx_load;
  logic [7:0] txf_dout;
  logic       tx_busy_q, tx_busy_d;
  logic [7:0] tx_hold_q;

  logic       rxf_empty, rxf_full, rxf_drop;
  logic [7:0] rxf_dout;
  logic       rx_hold_v_q;
  logic [7:0] rx_hold_q;

  logic       unused_wbits;
  assign unused_wbits = ^{reg_wdata[7], reg_wdata[5:3]};

  assign wr_data  = reg_wr && (reg_addr == LOC_DATA);
  assign wr_ctrl  = reg_wr && (reg_addr == LOC_CTRL);
  assign wr_stat  = reg_wr && (reg_addr == LOC_STAT);
  assign rd_data  = reg_rd && (reg_addr == LOC_DATA);
  assign rx_flush = wr_ctrl && reg_wdata[CTL_FLUSH_BIT];

  // transmit side
  uart_sfifo #(.W(8), .DEPTH(TX_DEPTH)) u_txf (
    .clk(clk), .rst_n(rst_n), .flush(1'b0),
    .push(wr_data), .din(reg_wdata),
    .pop(tx_load), .dout(txf_dout),
    .empty(txf_empty), .full(txf_full), .push_drop(txf_drop)
  );

  assign tx_load = !tx_busy_q && !txf_empty;

  always_comb begin
    tx_busy_d = tx_busy_q;
    if (tx_load)      tx_busy_d = 1'b1;
    else if (tx_done) tx_busy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_busy_q <= 1'b0;
      tx_hold_q <= '0;
    end else begin
      tx_busy_q <= tx_busy_d;
      if (tx_load) tx_hold_q <= txf_dout;
    end
  end

  assign tx_valid = tx_busy_q;
  assign tx_char  = tx_hold_q;

  // receive side
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_hold_v_q <= 1'b0;
      rx_hold_q   <= '0;
    end else begin
      rx_hold_v_q <= rx_in_valid;
      if (rx_in_valid) rx_hold_q <= rx_in_char;
    end
  end

  uart_sfifo #(.W(8), .DEPTH(RX_DEPTH)) u_rxf (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush),
    .push(rx_hold_v_q), .din(rx_hold_q),
    .pop(rd_data), .dout(rxf_dout),
    .empty(rxf_empty), .full(rxf_full), .push_drop(rxf_drop)
  );

  // control register
  always_comb begin
    en_d = en_q;
    if (wr_ctrl) en_d = reg_wdata[NUM_EV-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_d;
  end

  // events and interrupt
  always_comb begin
    evt           = '0;
    evt[EV_RXUND] = rd_data && rxf_empty;
    evt[EV_TXOVF] = txf_drop;
    evt[EV_RXOVF] = rxf_drop;
    clr           = wr_stat ? reg_wdata[NUM_EV-1:0] : '0;
  end

  uart_evt_flags #(.N(NUM_EV)) u_flags (
    .clk(clk), .rst_n(rst_n), .evt(evt), .clr(clr), .en(en_q),
    .flag(flag), .irq(irq)
  );

  // read mux
  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      LOC_DATA: reg_rdata = rxf_empty ? 8'h00 : rxf_dout;
      LOC_CTRL: reg_rdata[NUM_EV-1:0] = en_q;
      LOC_STAT: begin
        reg_rdata[ST_TXEMP_BIT]  = txf_empty;
        reg_rdata[ST_RXEMP_BIT]  = rxf_empty;
        reg_rdata[NUM_EV-1:0]    = flag;
      end
      default:  reg_rdata = '0;
    endcase
  end

  AST_UNDERFLOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && rxf_empty) |-> (reg_rdata == 8'h00)); // R6
  AST_TX_OVF_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && txf_full) |=> flag[EV_TXOVF]); // R3
  AST_RX_OVF_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_hold_v_q && rxf_full && !rx_flush) |=> flag[EV_RXOVF]); // R5
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == LOC_STAT) |-> (reg_rdata[5:3] == 3'b000)); // R11
endmodule

// File: tb/tb_uart_fifo_ctrl.sv
`timescale 1ns/1ps
module tb_uart_fifo_ctrl;
  logic       clk, rst_n;
  logic       reg_wr, reg_rd;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       tx_valid, tx_done, rx_in_valid, irq;
  logic [7:0] tx_char, rx_in_char;

  int checks = 0;
  int fails  = 0;
  bit done_flag = 0;

  uart_fifo_ctrl #(.TX_DEPTH(4), .RX_DEPTH(4)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_valid(tx_valid), .tx_char(tx_char), .tx_done(tx_done),
    .rx_in_valid(rx_in_valid), .rx_in_char(rx_in_char), .irq(irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%02h exp=%02h", tag, got, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic rx_send(input logic [7:0] c);
    rx_in_valid = 1'b1; rx_in_char = c;
    @(negedge clk);
    rx_in_valid = 1'b0;
  endtask

  task automatic tx_release;
    tx_done = 1'b1;
    @(negedge clk);
    tx_done = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    bus_rd(2, v); chk("R1 status after reset", v, 8'hC0);
    bus_rd(1, v); chk("R1 control after reset", v, 8'h00);
    chk("R1 irq after reset", {7'd0, irq}, 8'h00);
    bus_rd(3, v); chk("R11 unused location", v, 8'h00);
  endtask

  task automatic t_tx;
    logic [7:0] v;
    bus_wr(0, 8'h11);
    bus_rd(2, v); chk("R2 tx not empty after write", v, 8'h40);
    chk("R2 stage loaded", {7'd0, tx_valid}, 8'h01);
    chk("R2 stage char", tx_char, 8'h11);
    bus_rd(2, v); chk("R2 tx empty while stage busy", v, 8'hC0);
    bus_wr(0, 8'h22); bus_wr(0, 8'h33); bus_wr(0, 8'h44); bus_wr(0, 8'h55);
    bus_wr(0, 8'h66);
    bus_rd(2, v); chk("R3 tx overflow flag", v, 8'h42);
    bus_wr(2, 8'h00);
    bus_rd(2, v); chk("R8 write zero keeps flag", v, 8'h42);
    for (int i = 0; i < 4; i++) begin
      tx_release(); idle(1);
      chk("R2 tx order", tx_char, 8'h22 + 8'(i * 17));
    end
    tx_release(); idle(2);
    chk("R3 dropped char never sent", {7'd0, tx_valid}, 8'h00);
    bus_wr(2, 8'h02);
    bus_rd(2, v); chk("R8 w1c clears tx overflow", v, 8'hC0);
  endtask

  task automatic t_rx;
    logic [7:0] v;
    rx_send(8'hA1); rx_send(8'hA2); rx_send(8'hA3); idle(1);
    bus_rd(2, v); chk("R4 rx not empty", v, 8'h80);
    bus_rd(0, v); chk("R4 rx first", v, 8'hA1);
    bus_rd(0, v); chk("R4 rx second", v, 8'hA2);
    bus_rd(0, v); chk("R4 rx third", v, 8'hA3);
    bus_rd(2, v); chk("R4 rx empty after drain", v, 8'hC0);
  endtask

  task automatic t_underflow;
    logic [7:0] v;
    bus_rd(0, v); chk("R6 empty read returns zero", v, 8'h00);
    bus_rd(2, v); chk("R6 underflow flag", v, 8'hC1);
    bus_wr(2, 8'h01);
    bus_rd(2, v); chk("R8 w1c clears underflow", v, 8'hC0);
  endtask

  task automatic t_rx_overflow;
    logic [7:0] v;
    for (int i = 0; i < 5; i++) rx_send(8'hB0 + 8'(i));
    idle(1);
    bus_rd(2, v); chk("R5 rx overflow flag", v, 8'h84);
    for (int i = 0; i < 4; i++) begin
      bus_rd(0, v); chk("R5 kept chars", v, 8'hB0 + 8'(i));
    end
    bus_rd(2, v); chk("R5 fifth char dropped", v, 8'hC4);
    bus_wr(2, 8'h04);
    bus_rd(2, v); chk("R8 w1c clears rx overflow", v, 8'hC0);
  endtask

  task automatic t_flush;
    logic [7:0] v;
    rx_send(8'hC1); rx_send(8'hC2); idle(1);
    rx_send(8'h77);
    bus_wr(1, 8'h40);
    bus_rd(0, v); chk("R7 stage char survives flush", v, 8'h77);
    bus_rd(2, v); chk("R7 older chars flushed", v, 8'hC0);
    rx_send(8'hD1); idle(1);
    bus_wr(1, 8'h00);
    bus_rd(2, v); chk("R7 zero write keeps data", v, 8'h80);
    bus_rd(0, v); chk("R7 data intact", v, 8'hD1);
  endtask

  task automatic t_irq;
    logic [7:0] v;
    bus_rd(0, v); idle(2);
    chk("R10 irq masked", {7'd0, irq}, 8'h00);
    bus_wr(1, 8'h01); idle(1);
    chk("R10 irq with underflow enable", {7'd0, irq}, 8'h01);
    bus_wr(1, 8'h06); idle(1);
    chk("R10 other enables do not route", {7'd0, irq}, 8'h00);
    bus_wr(2, 8'h01);
    bus_wr(1, 8'hBF);
    bus_rd(1, v); chk("R11 control reserved bits", v, 8'h07);
    idle(1);
    chk("R10 irq low with no flags", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_same_cycle;
    logic [7:0] v;
    for (int i = 0; i < 5; i++) rx_send(8'hE0 + 8'(i));
    idle(1);
    rx_send(8'h99);
    bus_wr(2, 8'h04);
    bus_rd(2, v); chk("R9 event beats clear", v, 8'h84);
    idle(1);
    chk("R10 irq from rx overflow", {7'd0, irq}, 8'h01);
    bus_wr(2, 8'h04);
    bus_rd(2, v); chk("R8 clear after race", v, 8'h80);
  endtask

  initial begin
    #(200000 * 4);
    if (!done_flag) begin
      checks++; fails++;
      $display("FAIL watchdog got=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0;
    reg_wdata = '0; tx_done = 1'b0; rx_in_valid = 1'b0; rx_in_char = '0;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_tx();
    t_rx();
    t_underflow();
    t_rx_overflow();
    t_flush();
    t_irq();
    t_same_cycle();
    done_flag = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule